// File: doc/BRIEF.md
# ADC Power-Mode Pulse Sequencer

This block sits on the host side of a two-channel serial ADC that has no separate power-down pin. The converter works out its power state from the pattern on its convert-start line (CONV) and its serial clock (SCK). When SCK stays at one level, two CONV pulses put it into nap and four put it into sleep. Any SCK pulse wakes it from sleep. After that wake, its internal reference needs a long settling time before conversions can be trusted. The sequencer takes nap, sleep and wake commands and produces these pulse trains. It tracks which mode the converter is in and times the settling interval.

The normal conversion controller keeps its own CONV and SCK outputs. They pass through this block to the converter whenever the sequencer does not need the lines. A command is taken only when the sequencer is idle and the controller reports no frame in progress. While a pulse train or settling wait runs, or while the converter sleeps, the sequencer owns both lines. In that time it raises a hold output that keeps the controller from starting frames. Nap needs no wake-up sequence: the next normal frame brings the converter back.

Top module: `adc_pwr_seq`

## Requirements
- R1: A nap command (op code 01) accepted while the mode is active drives NAP_PULSES CONV pulses. Each pulse is PULSE_HI cycles high followed by PULSE_LO cycles low, and SCK stays at SCK_IDLE throughout. busy is high for NAP_PULSES*(PULSE_HI+PULSE_LO) cycles, starting with the cycle after the accepting edge. The mode then becomes nap.
- R2: A sleep command (op code 10) accepted while the mode is active or nap drives SLEEP_PULSES CONV pulses of the same shape, with SCK held at SCK_IDLE. The mode then becomes sleep.
- R3: A wake command (op code 11) accepted in sleep sets the mode to waking at once. It then drives WAKE_CLKS SCK pulses, each PULSE_HI cycles away from SCK_IDLE and PULSE_LO cycles at it, while CONV stays low.
- R4: After the wake clocks, a settling wait of CLK_HZ/1000*SETTLE_US/1000 cycles (at least 1) follows with busy still high. After the wait the mode is active and busy is low.
- R5: In nap, an accepted wake command, or fc_frame_i high while idle, returns the mode to active on the next edge. No pulses are issued and busy stays low.
- R6: Commands are ignored while busy is high or fc_frame_i is high. cmd_ready_o equals (not busy) and (not fc_frame_i).
- R7: Commands that do not fit the mode are ignored, leaving the lines and the mode unchanged. These are op 00, nap outside active, sleep in sleep, and wake in active.
- R8: When not busy and not in sleep, adc_conv_o and adc_sck_o follow fc_conv_i and fc_sck_i in the same cycle, and frame_hold_o is low.
- R9: In sleep, and at all times while busy, frame_hold_o is high. In sleep, adc_conv_o is low and adc_sck_o is SCK_IDLE whatever the controller drives.
- R10: mode_o encodes active=0, nap=1, sleep=2, waking=3. After reset the mode is active and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command: 00 none, 01 nap, 10 sleep, 11 wake |
| cmd_ready_o | output | 1 | A command would be taken this cycle |
| fc_frame_i | input | 1 | Conversion controller has a frame in progress |
| fc_conv_i | input | 1 | Controller CONV request |
| fc_sck_i | input | 1 | Controller SCK request |
| frame_hold_o | output | 1 | Controller must not start a frame |
| adc_conv_o | output | 1 | CONV line to the converter |
| adc_sck_o | output | 1 | SCK line to the converter |
| busy_o | output | 1 | Pulse train or settling wait running |
| mode_o | output | 2 | Tracked converter power mode |

## Verification
The bench builds the block with a 2-cycle high phase and a 3-cycle low phase, so that a swap of the two widths shows up. It uses two wake clocks and a high SCK idle level, so that the pulse count and the idle polarity are both exercised. The settling time is set to 1 us at 100 MHz, which gives a 100-cycle wait. With these values every path, including sleep entered from nap and a command arriving in the middle of a burst, can be compared cycle by cycle in a short run.

// File: rtl/apm_pkg.sv
package apm_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_NAP    = 2'd1,
    PM_SLEEP  = 2'd2,
    PM_WAKING = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_NAP   = 2'd1,
    OP_SLEEP = 2'd2,
    OP_WAKE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_BURST,
    SQ_WCLK,
    SQ_SETTLE
  } seq_e;
endpackage

// File: rtl/apm_pulse_train.sv
module apm_pulse_train #(
  parameter int   HI       = 2,
  parameter int   LO       = 2,
  parameter int   CNT_W    = 3,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             line_o,
  output logic             run_o,
  output logic             done_o
);
  localparam int WMAX  = (HI > LO) ? HI : LO;
  localparam int WID_W = $clog2(WMAX + 1);
  localparam logic [WID_W-1:0] HI_M1 = WID_W'(HI - 1);
  localparam logic [WID_W-1:0] LO_M1 = WID_W'(LO - 1);

  logic             run_q, run_d;
  logic             act_q, act_d;
  logic [WID_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             en;

  always_comb begin
    run_d  = run_q;
    act_d  = act_q;
    wcnt_d = wcnt_q;
    left_d = left_q;
    if (!run_q) begin
      if (start_i) begin
        run_d  = 1'b1;
        act_d  = 1'b1;
        wcnt_d = HI_M1;
        left_d = count_i - CNT_W'(1);
      end
    end else if (wcnt_q != '0) begin
      wcnt_d = wcnt_q - WID_W'(1);
    end else if (act_q) begin
      act_d  = 1'b0;
      wcnt_d = LO_M1;
    end else if (left_q == '0) begin
      run_d = 1'b0;
    end else begin
      act_d  = 1'b1;
      wcnt_d = HI_M1;
      left_d = left_q - CNT_W'(1);
    end
  end

  assign en = run_q | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      wcnt_q <= '0;
      left_q <= '0;
    end else if (en) begin
      run_q  <= run_d;
      act_q  <= act_d;
      wcnt_q <= wcnt_d;
      left_q <= left_d;
    end
  end

  assign line_o = act_q ? ~IDLE_LVL : IDLE_LVL;
  assign run_o  = run_q;
  assign done_o = run_q & ~act_q & (wcnt_q == '0) & (left_q == '0);

  // R1: a train is never asked for zero pulses
  a_r1_nonzero_count: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> count_i != '0);
  // R1: the line rests at its idle level whenever no train runs
  a_r1_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> line_o == IDLE_LVL);
  // R1: a train that finishes leaves the line idle on the next cycle
  a_r1_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (line_o == IDLE_LVL));
endmodule

// File: rtl/apm_settle.sv
module apm_settle #(
  parameter int CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int SET_W = $clog2(CYC + 1);
  localparam logic [SET_W-1:0] LOAD = SET_W'(CYC - 1);

  logic             run_q, run_d;
  logic [SET_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!run_q) begin
      if (start_i) begin
        run_d = 1'b1;
        cnt_d = LOAD;
      end
    end else if (cnt_q == '0) begin
      run_d = 1'b0;
    end else begin
      cnt_d = cnt_q - SET_W'(1);
    end
  end

  assign en = run_q | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign done_o = run_q & (cnt_q == '0);

  // R4: a wait is never restarted while one is running
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !start_i);
endmodule

// File: rtl/apm_seq_ctrl.sv
module apm_seq_ctrl
  import apm_pkg::*;
#(
  parameter int NAP_N   = 2,
  parameter int SLEEP_N = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic             frame_i,
  input  logic             burst_done_i,
  input  logic             wclk_done_i,
  input  logic             settle_done_i,
  output logic             conv_start_o,
  output logic [CNT_W-1:0] conv_count_o,
  output logic             sck_start_o,
  output logic             settle_start_o,
  output pmode_e           mode_o,
  output logic             busy_o,
  output logic             own_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] NAP_C   = CNT_W'(NAP_N);
  localparam logic [CNT_W-1:0] SLEEP_C = CNT_W'(SLEEP_N);

  seq_e   st_q, st_d;
  pmode_e mode_q, mode_d;
  pmode_e tgt_q, tgt_d;
  op_e    op;
  logic   accept;

  assign op     = op_e'(cmd_op_i);
  assign accept = (st_q == SQ_IDLE) & cmd_valid_i & ~frame_i;

  always_comb begin
    st_d           = st_q;
    mode_d         = mode_q;
    tgt_d          = tgt_q;
    conv_start_o   = 1'b0;
    conv_count_o   = NAP_C;
    sck_start_o    = 1'b0;
    settle_start_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_NAP: begin
              if (mode_q == PM_ACTIVE) begin
                conv_start_o = 1'b1;
                conv_count_o = NAP_C;
                tgt_d        = PM_NAP;
                st_d         = SQ_BURST;
              end
            end
            OP_SLEEP: begin
              if (mode_q == PM_ACTIVE || mode_q == PM_NAP) begin
                conv_start_o = 1'b1;
                conv_count_o = SLEEP_C;
                tgt_d        = PM_SLEEP;
                st_d         = SQ_BURST;
              end
            end
            OP_WAKE: begin
              if (mode_q == PM_SLEEP) begin
                sck_start_o = 1'b1;
                mode_d      = PM_WAKING;
                st_d        = SQ_WCLK;
              end else if (mode_q == PM_NAP) begin
                mode_d = PM_ACTIVE;
              end
            end
            default: ;
          endcase
        end else if (mode_q == PM_NAP && frame_i) begin
          mode_d = PM_ACTIVE;
        end
      end
      SQ_BURST: begin
        if (burst_done_i) begin
          mode_d = tgt_q;
          st_d   = SQ_IDLE;
        end
      end
      SQ_WCLK: begin
        if (wclk_done_i) begin
          settle_start_o = 1'b1;
          st_d           = SQ_SETTLE;
        end
      end
      SQ_SETTLE: begin
        if (settle_done_i) begin
          mode_d = PM_ACTIVE;
          st_d   = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      mode_q <= PM_ACTIVE;
      tgt_q  <= PM_ACTIVE;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      tgt_q  <= tgt_d;
    end
  end

  assign mode_o  = mode_q;
  assign busy_o  = (st_q != SQ_IDLE);
  assign own_o   = busy_o | (mode_q == PM_SLEEP);
  assign ready_o = ~busy_o & ~frame_i;

  // R3: the waking mode only exists while a sequence runs
  a_r3_waking_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_WAKING) |-> busy_o);
  // R4: the end of the settling wait leaves the converter active and idle
  a_r4_settle_to_active: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_SETTLE && settle_done_i) |=> (mode_q == PM_ACTIVE && !busy_o));
  // R6: a sequence only starts from idle with no frame in progress
  a_r6_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(!frame_i) && $past(cmd_valid_i)));
  // R5: leaving nap never starts a sequence
  a_r5_nap_exit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_NAP && !busy_o && frame_i) |=> !busy_o);
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import apm_pkg::*;
#(
  parameter int   CLK_HZ       = 100_000_000,
  parameter int   SETTLE_US    = 2000,
  parameter int   PULSE_HI     = 2,
  parameter int   PULSE_LO     = 2,
  parameter int   NAP_PULSES   = 2,
  parameter int   SLEEP_PULSES = 4,
  parameter int   WAKE_CLKS    = 1,
  parameter logic SCK_IDLE     = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  output logic       cmd_ready_o,
  input  logic       fc_frame_i,
  input  logic       fc_conv_i,
  input  logic       fc_sck_i,
  output logic       frame_hold_o,
  output logic       adc_conv_o,
  output logic       adc_sck_o,
  output logic       busy_o,
  output logic [1:0] mode_o
);
  localparam int SETTLE_RAW = (CLK_HZ / 1000) * SETTLE_US / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int MAXN_A     = (NAP_PULSES > SLEEP_PULSES) ? NAP_PULSES : SLEEP_PULSES;
  localparam int MAXN       = (MAXN_A > WAKE_CLKS) ? MAXN_A : WAKE_CLKS;
  localparam int CNT_W      = $clog2(MAXN + 1);
  localparam logic [CNT_W-1:0] WAKE_C = CNT_W'(WAKE_CLKS);

  logic             rst_meta_q, rst_sync_q;
  logic             conv_start, sck_start, settle_start;
  logic [CNT_W-1:0] conv_count;
  logic             conv_line, conv_run, conv_done;
  logic             sck_line, sck_run, sck_done;
  logic             settle_done;
  logic             own;
  pmode_e           mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  apm_seq_ctrl #(
    .NAP_N   (NAP_PULSES),
    .SLEEP_N (SLEEP_PULSES),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_op_i       (cmd_op_i),
    .frame_i        (fc_frame_i),
    .burst_done_i   (conv_done),
    .wclk_done_i    (sck_done),
    .settle_done_i  (settle_done),
    .conv_start_o   (conv_start),
    .conv_count_o   (conv_count),
    .sck_start_o    (sck_start),
    .settle_start_o (settle_start),
    .mode_o         (mode),
    .busy_o         (busy_o),
    .own_o          (own),
    .ready_o        (cmd_ready_o)
  );

  apm_pulse_train #(
    .HI (PULSE_HI), .LO (PULSE_LO), .CNT_W (CNT_W), .IDLE_LVL (1'b0)
  ) u_conv_train (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start_i (conv_start),
    .count_i (conv_count),
    .line_o  (conv_line),
    .run_o   (conv_run),
    .done_o  (conv_done)
  );

  apm_pulse_train #(
    .HI (PULSE_HI), .LO (PULSE_LO), .CNT_W (CNT_W), .IDLE_LVL (SCK_IDLE)
  ) u_sck_train (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start_i (sck_start),
    .count_i (WAKE_C),
    .line_o  (sck_line),
    .run_o   (sck_run),
    .done_o  (sck_done)
  );

  apm_settle #(
    .CYC (SETTLE_CYC)
  ) u_settle (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start_i (settle_start),
    .done_o  (settle_done)
  );

  assign adc_conv_o   = own ? conv_line : fc_conv_i;
  assign adc_sck_o    = own ? sck_line  : fc_sck_i;
  assign frame_hold_o = own;
  assign mode_o       = mode;

  // R1: SCK is frozen while a CONV train runs
  a_r1_sck_static: assert property (@(posedge clk) disable iff (!rst_sync_q)
    conv_run |-> (adc_sck_o == SCK_IDLE));
  // R3: CONV stays low while wake clocks run
  a_r3_conv_low_wake: assert property (@(posedge clk) disable iff (!rst_sync_q)
    sck_run |-> !adc_conv_o);
  // R9: a sleeping converter sees quiet lines and the controller is held off
  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mode_o == 2'd2) |-> (!adc_conv_o && adc_sck_o == SCK_IDLE && frame_hold_o));
  // R8: the controller reaches the converter when released
  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !frame_hold_o |-> (adc_conv_o == fc_conv_i && adc_sck_o == fc_sck_i));
  // R1: the two trains never run together
  a_r1_one_train: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones({conv_run, sck_run}) <= 1);
endmodule

// File: tb/test_adc_pwr_seq.sv
module test_adc_pwr_seq;
  localparam int   HI     = 2;
  localparam int   LO     = 3;
  localparam int   P      = HI + LO;
  localparam int   NAPN   = 2;
  localparam int   SLPN   = 4;
  localparam int   WAKN   = 2;
  localparam logic IDLE   = 1'b1;
  localparam int   SETTLE = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic       cmd_ready, fc_frame, fc_conv, fc_sck;
  logic       frame_hold, adc_conv, adc_sck, busy;
  logic [1:0] mode;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  bit    chk_en = 0;
  string cur_req = "R10";

  int m_mode, m_kind, m_t, m_tgt;
  int conv_rises, sck_pulses, busy_cycles;
  logic prev_conv, prev_sck;

  always #5 clk = ~clk;

  adc_pwr_seq #(
    .CLK_HZ (100_000_000), .SETTLE_US (1), .PULSE_HI (HI), .PULSE_LO (LO),
    .NAP_PULSES (NAPN), .SLEEP_PULSES (SLPN), .WAKE_CLKS (WAKN), .SCK_IDLE (IDLE)
  ) i_adc_pwr_seq (
    .clk (clk), .rst_n (rst_n), .cmd_valid_i (cmd_valid), .cmd_op_i (cmd_op),
    .cmd_ready_o (cmd_ready), .fc_frame_i (fc_frame), .fc_conv_i (fc_conv),
    .fc_sck_i (fc_sck), .frame_hold_o (frame_hold), .adc_conv_o (adc_conv),
    .adc_sck_o (adc_sck), .busy_o (busy), .mode_o (mode)
  );

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_kind = 0; m_t = 0; m_tgt = 0;
    end else begin
      case (m_kind)
        1, 2: begin
          m_t++;
          if (m_t == ((m_kind == 1) ? NAPN : SLPN) * P) begin
            m_kind = 0; m_mode = m_tgt;
          end
        end
        3: begin
          m_t++;
          if (m_t == WAKN * P) begin m_kind = 4; m_t = 0; end
        end
        4: begin
          m_t++;
          if (m_t == SETTLE) begin m_kind = 0; m_mode = 0; end
        end
        default: begin
          if (cmd_valid && !fc_frame) begin
            if (cmd_op == 2'd1 && m_mode == 0) begin
              m_kind = 1; m_t = 0; m_tgt = 1;
            end else if (cmd_op == 2'd2 && (m_mode == 0 || m_mode == 1)) begin
              m_kind = 2; m_t = 0; m_tgt = 2;
            end else if (cmd_op == 2'd3 && m_mode == 2) begin
              m_kind = 3; m_t = 0; m_mode = 3;
            end else if (cmd_op == 2'd3 && m_mode == 1) begin
              m_mode = 0;
            end
          end else if (m_mode == 1 && fc_frame) begin
            m_mode = 0;
          end
        end
      endcase
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    bit   eb, eo;
    logic ec, es;
    int   pos;
    if (chk_en && !done) begin
      eb  = (m_kind != 0);
      eo  = eb || (m_mode == 2);
      pos = m_t % P;
      ec  = (m_kind == 1 || m_kind == 2) ? (pos < HI) : (eo ? 1'b0 : fc_conv);
      es  = (m_kind == 3) ? ((pos < HI) ? ~IDLE : IDLE) : (eo ? IDLE : fc_sck);
      checks++;
      if (busy !== eb || mode !== 2'(m_mode) || adc_conv !== ec || adc_sck !== es ||
          frame_hold !== eo || cmd_ready !== (!eb && !fc_frame)) begin
        errors++;
        $display("FAIL %s cycle: busy=%0b/%0b mode=%0d/%0d conv=%0b/%0b sck=%0b/%0b hold=%0b/%0b ready=%0b/%0b (actual/expected)",
                 cur_req, busy, eb, mode, m_mode, adc_conv, ec, adc_sck, es,
                 frame_hold, eo, cmd_ready, (!eb && !fc_frame));
      end
      if (adc_conv === 1'b1 && prev_conv === 1'b0) conv_rises++;
      if (adc_sck === ~IDLE && prev_sck === IDLE) sck_pulses++;
      if (busy === 1'b1) busy_cycles++;
      prev_conv = adc_conv;
      prev_sck  = adc_sck;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic issue(input logic [1:0] op);
    cmd_valid = 1'b1; cmd_op = op;
    cyc(1);
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic clear_counts();
    conv_rises = 0; sck_pulses = 0; busy_cycles = 0;
  endtask

  task automatic expect_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0;
    fc_frame = 1'b0; fc_conv = 1'b0; fc_sck = IDLE;
    prev_conv = 1'b0; prev_sck = IDLE;
    clear_counts();
    cyc(2);
    chk_en = 1;
    cur_req = "R10";
    expect_int("R10", "reset mode", int'(mode), 0);
    expect_int("R10", "reset busy", int'(busy), 0);
    rst_n = 1'b1;
    cyc(5);

    // R8 pass-through with mixed patterns
    cur_req = "R8";
    for (int i = 0; i < 8; i++) begin
      fc_conv = i[0]; fc_sck = i[1]; fc_frame = i[2];
      cyc(1);
    end
    fc_frame = 1'b0; fc_conv = 1'b0; fc_sck = IDLE;
    expect_int("R8", "hold low when active", int'(frame_hold), 0);

    // R7 misfit commands in active
    cur_req = "R7";
    clear_counts();
    issue(2'd3); issue(2'd0);
    cyc(3);
    expect_int("R7", "mode after wake in active", int'(mode), 0);
    expect_int("R7", "busy cycles after misfit", busy_cycles, 0);

    // R6 command blocked by frame in progress
    cur_req = "R6";
    fc_frame = 1'b1;
    issue(2'd1);
    fc_frame = 1'b0;
    cyc(2);
    expect_int("R6", "nap blocked by frame", int'(mode), 0);

    // R1 nap
    cur_req = "R1";
    clear_counts();
    issue(2'd1);
    cyc(NAPN * P + 2);
    expect_int("R1", "nap conv pulses", conv_rises, NAPN);
    expect_int("R1", "nap busy cycles", busy_cycles, NAPN * P);
    expect_int("R1", "mode after nap", int'(mode), 1);
    expect_int("R1", "sck pulses during nap", sck_pulses, 0);

    // R7 nap while in nap; R5 wake from nap
    cur_req = "R7";
    issue(2'd1);
    cyc(2);
    expect_int("R7", "nap in nap ignored", int'(mode), 1);
    cur_req = "R5";
    clear_counts();
    issue(2'd3);
    expect_int("R5", "wake from nap", int'(mode), 0);
    cyc(2);
    expect_int("R5", "no busy on nap exit", busy_cycles, 0);

    // R5 frame leaves nap
    cur_req = "R1";
    issue(2'd1);
    cyc(NAPN * P + 1);
    cur_req = "R5";
    fc_frame = 1'b1; fc_conv = 1'b1;
    cyc(1);
    expect_int("R5", "frame leaves nap", int'(mode), 0);
    fc_frame = 1'b0; fc_conv = 1'b0;
    cyc(2);

    // R2 sleep from active, with a command during the burst (R6)
    cur_req = "R2";
    clear_counts();
    issue(2'd2);
    cyc(3);
    cur_req = "R6";
    expect_int("R6", "ready low while busy", int'(cmd_ready), 0);
    issue(2'd3);
    cur_req = "R2";
    cyc(SLPN * P);
    expect_int("R2", "sleep conv pulses", conv_rises, SLPN);
    expect_int("R2", "mode after sleep", int'(mode), 2);

    // R9 quiet lines in sleep; R7 misfits in sleep
    cur_req = "R9";
    clear_counts();
    for (int i = 0; i < 6; i++) begin
      fc_conv = i[0]; fc_sck = ~i[0];
      cyc(1);
    end
    fc_conv = 1'b0; fc_sck = IDLE;
    expect_int("R9", "no conv in sleep", conv_rises, 0);
    expect_int("R9", "hold high in sleep", int'(frame_hold), 1);
    cur_req = "R7";
    issue(2'd2); issue(2'd1);
    cyc(2);
    expect_int("R7", "sleep/nap in sleep ignored", int'(mode), 2);

    // R3 and R4 wake
    cur_req = "R3";
    clear_counts();
    issue(2'd3);
    expect_int("R3", "waking at once", int'(mode), 3);
    cyc(WAKN * P);
    expect_int("R3", "wake sck pulses", sck_pulses, WAKN);
    expect_int("R3", "no conv during wake", conv_rises, 0);
    cur_req = "R4";
    cyc(SETTLE + 3);
    expect_int("R4", "wake busy cycles", busy_cycles, WAKN * P + SETTLE);
    expect_int("R4", "active after settle", int'(mode), 0);

    // R2 sleep from nap, then wake again
    cur_req = "R1";
    issue(2'd1);
    cyc(NAPN * P + 1);
    cur_req = "R2";
    clear_counts();
    issue(2'd2);
    cyc(SLPN * P + 1);
    expect_int("R2", "sleep from nap pulses", conv_rises, SLPN);
    expect_int("R2", "sleep from nap mode", int'(mode), 2);
    cur_req = "R3";
    issue(2'd3);
    cyc(WAKN * P + SETTLE + 2);
    expect_int("R4", "active after second wake", int'(mode), 0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not end actual=hung expected=done");
      finish_run();
    end
  end
endmodule